// File: doc/BRIEF.md
# Crossbar Port Arbitration Scheduler

This block decides which source port of a packet routing switch is connected to which destination port. Every source port presents a request flag and a destination-enable vector taken from a routing lookup. A bit set in that vector means the packet may leave through that destination. More than one bit set means the packet may use any of those destinations to share load. There is one arbiter per destination port and no central scheduler, and the block holds no packets. Each destination arbiter picks one waiting source and holds that connection until the source reports the end of its packet.

The block runs in the parallel-data clock domain. Connections are set up as headers arrive, with one register stage, so short packets cost only that single cycle of set-up. Grants are registered, one-hot, and given in two views. The per-destination view drives the output multiplexers. The per-source view tells each source which output it owns. A request whose enable vector is empty raises a one-cycle invalid-destination flag for that source instead of a grant.

Top module: `xbar_sched`

## Requirements
- R1: While `rst_n` is low at a clock edge, every grant bit and every `err_nodest` bit is 0 after that edge.
- R2: A source that requests (`req_vld[s]`=1) at an edge, holds nothing, and has enable bit d set with destination d free at that edge is granted by d after that same edge. Bit `d*NPORT+s` of `grant_by_dst` and bit `s*NPORT+d` of `grant_by_src` become 1. A grant never appears without such a request at the preceding edge.
- R3: When several sources target the same free destination at one edge, the lowest-numbered source receives the grant.
- R4: A source whose enable vector has several bits set, all free, is claimed by the lowest-numbered enabled destination.
- R5: When lower enabled destinations are busy, the source is claimed by the lowest enabled destination that is free.
- R6: A grant stays in place while its source does not assert `pkt_end`, whatever that source's `req_vld` and enable vector do meanwhile.
- R7: `pkt_end[s]` sampled at an edge while s holds destination d clears that grant after the edge. A request waiting for d is granted at the following edge, not at the edge that released it.
- R8: Each destination grants at most one source, and each source holds at most one destination, in every cycle.
- R9: A request with an all-zero enable vector from a source that holds nothing sets `err_nodest[s]` for one cycle after that edge and produces no grant.
- R10: `pkt_end` from a source that holds no destination changes no grant.
- R11: A source that loses its chosen destination to a lower-numbered source tries again at the next edge, against the destinations free at that time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parallel-data clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_vld | input | NPORT | Per source: a packet header is waiting for a connection |
| req_dest | input | NPORT*NPORT | Per source s, bits s*NPORT+d: destination d is allowed |
| pkt_end | input | NPORT | Per source: terminating character forwarded this cycle |
| grant_by_dst | output | NPORT*NPORT | Bit d*NPORT+s: destination d is connected to source s |
| grant_by_src | output | NPORT*NPORT | Bit s*NPORT+d: source s is connected to destination d |
| err_nodest | output | NPORT | Per source: one-cycle invalid-destination flag |

## Verification
The assertions assume that `pkt_end` means something only for a source that holds a grant. They also assume inputs change only between clock edges and that a source's request vector stays readable for the edge that acts on it. The bench drives every input just after a falling edge. Its directed sections raise `pkt_end` only on purpose, to exercise R7 and R10. The random phase holds requests steady while they wait, so every grant can be traced to a request at the edge before it.

// File: rtl/xbar_sched_pkg.sv
// Package: shared constants for the crossbar scheduler.
// Assumes: nothing; holds only elaboration-time values.
package xbar_sched_pkg;
    // Largest port count the scheduler is specified for.
    localparam int MAX_PORTS = 32;
    // Default port count used when the block is elaborated on its own.
    localparam int DEF_PORTS = 8;
endpackage

// File: rtl/xbar_src_select.sv
// Module: per-source destination choice.
// Picks, for one source that is waiting and holds nothing, the lowest
// enabled destination that is free this cycle, and flags an empty
// enable vector. Purely combinational.
// Assumes: dst_free reflects registered destination state.
module xbar_src_select #(
    parameter int NPORT = xbar_sched_pkg::DEF_PORTS
) (
    input  logic             req_vld,
    input  logic             held,
    input  logic [NPORT-1:0] dest_en,
    input  logic [NPORT-1:0] dst_free,
    output logic [NPORT-1:0] target,
    output logic             no_dest
);
    logic             waiting;
    logic [NPORT-1:0] eligible;
    logic             seen;

    // A source competes only when it requests and holds no destination.
    assign waiting  = req_vld && !held;
    assign eligible = waiting ? (dest_en & dst_free) : '0;
    assign no_dest  = waiting && (dest_en == '0);

    // Keep only the lowest eligible destination.
    always_comb begin
        seen   = 1'b0;
        target = '0;
        for (int d = 0; d < NPORT; d++) begin
            target[d] = eligible[d] && !seen;
            seen      = seen || eligible[d];
        end
    end
endmodule

// File: rtl/xbar_dst_arbiter.sv
// Module: one destination port's arbiter.
// Holds a one-hot owner register. When free, grants the lowest-numbered
// candidate source; when busy, releases on the owner's end-of-packet.
// Assumes: cand only contains sources that hold nothing.
module xbar_dst_arbiter #(
    parameter int NPORT = xbar_sched_pkg::DEF_PORTS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPORT-1:0] cand,
    input  logic [NPORT-1:0] src_end,
    output logic [NPORT-1:0] owner,
    output logic             busy
);
    logic [NPORT-1:0] winner;
    logic [NPORT-1:0] owner_n;
    logic             seen;

    assign busy = |owner;

    // Fixed priority: lowest-numbered candidate wins.
    always_comb begin
        seen   = 1'b0;
        winner = '0;
        for (int s = 0; s < NPORT; s++) begin
            winner[s] = cand[s] && !seen;
            seen      = seen || cand[s];
        end
    end

    // Next owner: release on end of packet, grant only when free.
    always_comb begin
        if (busy) begin
            owner_n = (|(owner & src_end)) ? '0 : owner;
        end else begin
            owner_n = winner;
        end
    end

    // Owner register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner <= '0;
        end else begin
            owner <= owner_n;
        end
    end
endmodule

// File: rtl/xbar_sched.sv
// Module: crossbar scheduler top.
// One xbar_src_select per source and one xbar_dst_arbiter per
// destination; exposes registered grants in two layouts and a
// registered invalid-destination flag.
// Assumes: NPORT between 2 and xbar_sched_pkg::MAX_PORTS.
module xbar_sched #(
    parameter int NPORT = xbar_sched_pkg::DEF_PORTS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NPORT-1:0]       req_vld,
    input  logic [NPORT*NPORT-1:0] req_dest,
    input  logic [NPORT-1:0]       pkt_end,
    output logic [NPORT*NPORT-1:0] grant_by_dst,
    output logic [NPORT*NPORT-1:0] grant_by_src,
    output logic [NPORT-1:0]       err_nodest
);
    localparam int GW = NPORT * NPORT;

    logic [NPORT-1:0][NPORT-1:0] tgt;    // [source][destination]
    logic [NPORT-1:0][NPORT-1:0] cand;   // [destination][source]
    logic [NPORT-1:0][NPORT-1:0] owner;  // [destination][source]
    logic [NPORT-1:0][NPORT-1:0] owned;  // [source][destination]
    logic [NPORT-1:0]            busy;
    logic [NPORT-1:0]            held;
    logic [NPORT-1:0]            nodest;

    // Transpose the owner and target matrices.
    for (genvar s = 0; s < NPORT; s++) begin : g_xpose_s
        for (genvar d = 0; d < NPORT; d++) begin : g_xpose_d
            assign cand[d][s]               = tgt[s][d];
            assign owned[s][d]              = owner[d][s];
            assign grant_by_dst[d*NPORT+s]  = owner[d][s];
            assign grant_by_src[s*NPORT+d]  = owner[d][s];
        end
        assign held[s] = |owned[s];
    end

    // Per-source choice of destination.
    for (genvar s = 0; s < NPORT; s++) begin : g_src
        xbar_src_select #(.NPORT(NPORT)) u_sel (
            .req_vld  (req_vld[s]),
            .held     (held[s]),
            .dest_en  (req_dest[s*NPORT +: NPORT]),
            .dst_free (~busy),
            .target   (tgt[s]),
            .no_dest  (nodest[s])
        );
    end

    // Per-destination arbiters.
    for (genvar d = 0; d < NPORT; d++) begin : g_dst
        xbar_dst_arbiter #(.NPORT(NPORT)) u_arb (
            .clk     (clk),
            .rst_n   (rst_n),
            .cand    (cand[d]),
            .src_end (pkt_end),
            .owner   (owner[d]),
            .busy    (busy[d])
        );
    end

    // Register the invalid-destination flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_nodest <= '0;
        end else begin
            err_nodest <= nodest;
        end
    end

    logic unused_gw;
    assign unused_gw = (GW == 0);
endmodule

// File: rtl/xbar_sched_chk.sv
// Module: assertion checker for xbar_sched, bound to every instance.
// Assumes: pkt_end is meaningful only for sources holding a grant.
module xbar_sched_chk #(
    parameter int NPORT = xbar_sched_pkg::DEF_PORTS
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NPORT-1:0]       req_vld,
    input logic [NPORT*NPORT-1:0] req_dest,
    input logic [NPORT-1:0]       pkt_end,
    input logic [NPORT*NPORT-1:0] grant_by_dst,
    input logic [NPORT*NPORT-1:0] grant_by_src,
    input logic [NPORT-1:0]       err_nodest
);
    for (genvar s = 0; s < NPORT; s++) begin : g_s
        // R8: a source holds at most one destination.
        p_src_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(grant_by_src[s*NPORT +: NPORT]));
        // R9: empty enable vector gives the flag and no grant.
        p_nodest_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (req_vld[s] && req_dest[s*NPORT +: NPORT] == '0
             && grant_by_src[s*NPORT +: NPORT] == '0)
            |=> (err_nodest[s] && grant_by_src[s*NPORT +: NPORT] == '0));
        for (genvar d = 0; d < NPORT; d++) begin : g_d
            // R6: a grant persists until its source ends the packet.
            p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (grant_by_dst[d*NPORT+s] && !pkt_end[s]) |=> grant_by_dst[d*NPORT+s]);
            // R7: end of packet drops the grant after the edge.
            p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (grant_by_dst[d*NPORT+s] && pkt_end[s]) |=> !grant_by_dst[d*NPORT+s]);
            // R2: a new grant always follows a matching request.
            p_new_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(grant_by_dst[d*NPORT+s]) |-> $past(req_vld[s] && req_dest[s*NPORT+d]));
        end
    end
    for (genvar d = 0; d < NPORT; d++) begin : g_dd
        // R8: a destination grants at most one source.
        p_dst_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(grant_by_dst[d*NPORT +: NPORT]));
    end
endmodule

bind xbar_sched xbar_sched_chk #(.NPORT(NPORT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_vld      (req_vld),
    .req_dest     (req_dest),
    .pkt_end      (pkt_end),
    .grant_by_dst (grant_by_dst),
    .grant_by_src (grant_by_src),
    .err_nodest   (err_nodest)
);

// File: tb/xbar_sched_tb.sv
// Bench: behavioural reference model compared on every clock.
module xbar_sched_tb;
    localparam int NP = 8;
    localparam time CLK_PERIOD = 10ns;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP-1:0]     req_vld = '0;
    logic [NP*NP-1:0]  req_dest = '0;
    logic [NP-1:0]     pkt_end = '0;
    logic [NP*NP-1:0]  grant_by_dst;
    logic [NP*NP-1:0]  grant_by_src;
    logic [NP-1:0]     err_nodest;

    int    own[NP];
    bit    err_m[NP];
    int    vectors = 0;
    int    fails = 0;
    bit    done = 1'b0;
    string tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    xbar_sched #(.NPORT(NP)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_dest(req_dest),
        .pkt_end(pkt_end), .grant_by_dst(grant_by_dst),
        .grant_by_src(grant_by_src), .err_nodest(err_nodest));

    // Reference model: advance one clock edge from the sampled inputs.
    task automatic model_edge();
        int  nown[NP];
        int  tgt[NP];
        bit  busy[NP];
        bit  held[NP];
        if (!rst_n) begin
            foreach (own[i]) begin own[i] = -1; err_m[i] = 0; end
            return;
        end
        foreach (own[d]) begin busy[d] = 0; held[d] = 0; end
        foreach (own[d]) if (own[d] >= 0) begin busy[d] = 1; held[own[d]] = 1; end
        for (int s = 0; s < NP; s++) begin
            tgt[s] = -1; err_m[s] = 0;
            if (req_vld[s] && !held[s]) begin
                if (req_dest[s*NP +: NP] == '0) err_m[s] = 1;
                else for (int d = 0; d < NP; d++)
                    if (req_dest[s*NP+d] && !busy[d]) begin tgt[s] = d; break; end
            end
        end
        for (int d = 0; d < NP; d++) begin
            nown[d] = own[d];
            if (busy[d]) begin
                if (pkt_end[own[d]]) nown[d] = -1;
            end else begin
                for (int s = 0; s < NP; s++)
                    if (tgt[s] == d) begin nown[d] = s; break; end
            end
        end
        foreach (own[d]) own[d] = nown[d];
    endtask

    // Compare every output against the model.
    task automatic compare();
        logic [NP*NP-1:0] ed, es;
        logic [NP-1:0]    ee;
        ed = '0; es = '0; ee = '0;
        for (int d = 0; d < NP; d++)
            if (own[d] >= 0) begin ed[d*NP+own[d]] = 1; es[own[d]*NP+d] = 1; end
        for (int s = 0; s < NP; s++) ee[s] = err_m[s];
        vectors++;
        if (grant_by_dst !== ed || grant_by_src !== es || err_nodest !== ee) begin
            fails++;
            $display("FAIL %s: dst=%h src=%h err=%h expected dst=%h src=%h err=%h",
                     tag, grant_by_dst, grant_by_src, err_nodest, ed, es, ee);
        end
    endtask

    // Directed check: destination d grants source s (s<0 means none).
    task automatic expect_dst(int d, int s, string rq);
        logic [NP-1:0] e;
        e = '0;
        if (s >= 0) e[s] = 1;
        vectors++;
        if (grant_by_dst[d*NP +: NP] !== e) begin
            fails++;
            $display("FAIL %s: dest %0d grant=%b expected %b", rq, d, grant_by_dst[d*NP +: NP], e);
        end
    endtask

    // One clock: model at the edge, compare after the falling edge.
    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_edge();
            @(negedge clk);
            compare();
        end
    endtask

    task automatic set_req(int s, logic [NP-1:0] en);
        req_vld[s] = (en != '0) || req_vld[s];
        req_dest[s*NP +: NP] = en;
        req_vld[s] = 1'b1;
    endtask

    task automatic clear_all();
        req_vld = '0; req_dest = '0;
        pkt_end = '1;
        step();
        pkt_end = '0;
        step();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin : main
        foreach (own[i]) begin own[i] = -1; err_m[i] = 0; end
        @(negedge clk);
        // R1: reset with requests present.
        tag = "R1";
        req_vld = '1; req_dest = '1;
        step(3);
        expect_dst(0, -1, "R1");
        req_vld = '0; req_dest = '0;
        rst_n = 1'b1;
        step();

        // R2: single request granted after one edge.
        tag = "R2";
        set_req(2, 8'b0010_0000);
        step();
        expect_dst(5, 2, "R2");

        // R6: request changes while held are ignored.
        tag = "R6";
        set_req(2, 8'b0000_0001);
        step(3);
        expect_dst(5, 2, "R6");
        expect_dst(0, -1, "R6");

        // R7: release, then regrant one edge later.
        tag = "R7";
        set_req(2, 8'b0010_0000);
        pkt_end[2] = 1'b1;
        step();
        pkt_end[2] = 1'b0;
        expect_dst(5, -1, "R7");
        step();
        expect_dst(5, 2, "R7");
        clear_all();

        // R3: three sources contend for destination 0.
        tag = "R3";
        set_req(1, 8'b0000_0001);
        set_req(3, 8'b0000_0001);
        set_req(6, 8'b0000_0001);
        step();
        expect_dst(0, 1, "R3");
        pkt_end[1] = 1'b1; req_vld[1] = 1'b0;
        step();
        pkt_end[1] = 1'b0;
        step();
        expect_dst(0, 3, "R3");
        clear_all();

        // R4: load sharing picks the lowest enabled free destination.
        tag = "R4";
        set_req(4, 8'b0000_1110);
        step();
        expect_dst(1, 4, "R4");

        // R5: lowest enabled is busy, next free one is used.
        tag = "R5";
        set_req(5, 8'b0000_0110);
        step();
        expect_dst(2, 5, "R5");
        clear_all();

        // R11: loser retries against the next free destination.
        tag = "R11";
        set_req(0, 8'b0100_0000);
        set_req(7, 8'b1100_0000);
        step();
        expect_dst(6, 0, "R11");
        expect_dst(7, -1, "R11");
        step();
        expect_dst(7, 7, "R11");

        // R10: end-of-packet from a non-holder changes nothing.
        tag = "R10";
        pkt_end[3] = 1'b1;
        step();
        pkt_end[3] = 1'b0;
        expect_dst(6, 0, "R10");
        expect_dst(7, 7, "R10");
        clear_all();

        // R9: empty enable vector raises the flag for one cycle.
        tag = "R9";
        req_vld[4] = 1'b1; req_dest[4*NP +: NP] = '0;
        step();
        vectors++;
        if (err_nodest !== 8'b0001_0000) begin
            fails++;
            $display("FAIL R9: err=%b expected %b", err_nodest, 8'b0001_0000);
        end
        req_vld[4] = 1'b0;
        step();
        vectors++;
        if (err_nodest !== '0) begin
            fails++;
            $display("FAIL R9: err=%b expected %b", err_nodest, 8'b0);
        end

        // R8: random traffic compared with the model every cycle.
        tag = "R8";
        for (int c = 0; c < 3000; c++) begin
            for (int s = 0; s < NP; s++) begin
                if (!req_vld[s] && ($urandom_range(3) == 0)) begin
                    req_vld[s] = 1'b1;
                    req_dest[s*NP +: NP] = ($urandom_range(9) == 0) ? '0 : NP'($urandom);
                end
                pkt_end[s] = ($urandom_range(5) == 0);
                if (pkt_end[s] && ($urandom_range(1) == 0)) req_vld[s] = 1'b0;
            end
            step();
        end
        req_vld = '0; pkt_end = '0;
        step(2);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule